// File: doc/BRIEF.md
# Packet Fill FIFO

This block is a single-clock stream buffer placed between a producer that may pause in the middle of a packet and a sink that must receive every frame without gaps, such as an Ethernet MAC. Words enter and leave through valid/ready handshakes. Each word carries start-of-packet and end-of-packet flags.

The output stays quiet while a packet is being collected. It opens once the buffer holds a full output packet's worth of words, or once a packet's end marker has been stored. The open packet then streams out as fast as the sink accepts it. After its last word leaves, the output closes again until the next release condition is met.

The release threshold is one output packet: words per block times blocks per packet. The total depth is that threshold plus the header length plus ten spare words. The spare room lets the upstream path keep flowing while a later stage stalls this buffer to insert a header.

Top module: `pkt_fill_fifo`

## Requirements
- R1: Words leave in the order they were accepted, with their data unchanged.
- R2: The start flag (`out_sop`) and end flag (`out_eop`) of each output word equal those the word carried on input.
- R3: `in_ready` is low exactly when DEPTH words are stored. While it is low, an offered word is not taken, and no accepted word is ever lost.
- R4: `out_valid` stays low until the stored word count reaches FILL, or until a word with the end flag is stored. With the defaults FILL is 8 (4 words per block times 2 blocks).
- R5: Once a packet of at most FILL words has begun to leave, `out_valid` is high in every cycle until its end-flagged word is taken.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data`, `out_sop` and `out_eop` hold steady into the next cycle.
- R7: In the cycle after an end-flagged word is taken, `out_valid` is low, and the next release waits for the R4 condition again.
- R8: Reset empties the buffer and returns the release state to waiting: `out_valid` is low, `in_ready` is high, and words stored before reset never appear afterwards.
- R9: The capacity is FILL + HDR_WORDS + 10 words (20 with the defaults), so `in_ready` falls right after the 20th word is accepted with no reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Buffer can take a word |
| in_data | input | DATA_W | Input word |
| in_sop | input | 1 | Input word starts a packet |
| in_eop | input | 1 | Input word ends a packet |
| out_valid | output | 1 | Released word available |
| out_ready | input | 1 | Sink takes the word |
| out_data | output | DATA_W | Output word |
| out_sop | output | 1 | Output word starts a packet |
| out_eop | output | 1 | Output word ends a packet |

## Verification
The hardest situation to reach from the ports is the release by count alone: the threshold has been met but no end marker is stored yet. The bench reaches it by holding `out_ready` low, feeding eight words of a twelve-word packet, pausing the producer, and then checking that the output has opened. Two other states also take deliberate stimulus. To fill the buffer completely, the sink is stalled across five packets, and a surplus word is then offered and must be refused. To reset while a release is in progress, a long packet is started before the reset, and the bench then checks that none of its words come out afterwards.

// File: rtl/pff_pkg.sv
package pff_pkg;

  typedef enum logic {
    GATE_HOLD = 1'b0,
    GATE_RUN  = 1'b1
  } gate_e;

  // Words in one full output packet.
  function automatic int unsigned pkt_words(input int unsigned blk_words,
                                            input int unsigned blks);
    return blk_words * blks;
  endfunction

  // Storage needed: one packet, one header stall, plus spare words.
  function automatic int unsigned fifo_depth(input int unsigned fill,
                                             input int unsigned hdr,
                                             input int unsigned spare);
    return fill + hdr + spare;
  endfunction

  // Bits to count from zero up to and including maxv.
  function automatic int unsigned cnt_width(input int unsigned maxv);
    return $clog2(maxv + 1);
  endfunction

endpackage

// File: rtl/pff_store.sv
module pff_store #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned DEPTH  = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_word,
  input  logic              rd_en,
  output logic [WORD_W-1:0] rd_word
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr;
  logic [PTR_W-1:0]  rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_en) wr_ptr <= ptr_step(wr_ptr);
      if (rd_en) rd_ptr <= ptr_step(rd_ptr);
    end
  end

  assign rd_word = mem[rd_ptr];

endmodule

// File: rtl/pff_level.sv
module pff_level #(
  parameter int unsigned DEPTH = 20,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             push_eop,
  input  logic             pop,
  input  logic             pop_eop,
  output logic [LVL_W-1:0] level,
  output logic [LVL_W-1:0] eops,
  output logic             full,
  output logic             empty
);
  wire eop_in  = push & push_eop;
  wire eop_out = pop & pop_eop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level <= '0;
      eops  <= '0;
    end else begin
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
      case ({eop_in, eop_out})
        2'b10:   eops <= eops + 1'b1;
        2'b01:   eops <= eops - 1'b1;
        default: eops <= eops;
      endcase
    end
  end

  assign full  = (level == LVL_W'(DEPTH));
  assign empty = (level == '0);

endmodule

// File: rtl/pff_gate.sv
module pff_gate
  import pff_pkg::*;
#(
  parameter int unsigned FILL  = 8,
  parameter int unsigned LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] eops,
  input  logic             empty,
  input  logic             pop,
  input  logic             pop_eop,
  output logic             busy,
  output logic             release_ok
);
  gate_e state;
  logic  start_ok;

  assign start_ok = (level >= LVL_W'(FILL)) || (eops != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= GATE_HOLD;
    end else begin
      case (state)
        GATE_HOLD: if (start_ok)       state <= GATE_RUN;
        GATE_RUN:  if (pop && pop_eop) state <= GATE_HOLD;
        default:                       state <= GATE_HOLD;
      endcase
    end
  end

  assign busy       = (state == GATE_RUN);
  assign release_ok = busy && !empty;

endmodule

// File: rtl/pkt_fill_fifo.sv
module pkt_fill_fifo
  import pff_pkg::*;
#(
  parameter int unsigned DATA_W         = 16,
  parameter int unsigned BLOCK_WORDS    = 4,
  parameter int unsigned BLOCKS_PER_PKT = 2,
  parameter int unsigned HDR_WORDS      = 2,
  parameter int unsigned SPARE_WORDS    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sop,
  input  logic              in_eop,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop
);
  localparam int unsigned FILL   = pkt_words(BLOCK_WORDS, BLOCKS_PER_PKT);
  localparam int unsigned DEPTH  = fifo_depth(FILL, HDR_WORDS, SPARE_WORDS);
  localparam int unsigned LVL_W  = cnt_width(DEPTH);
  localparam int unsigned WORD_W = DATA_W + 2;

  // Named internal events, also observed by the bound checker.
  logic             pushed;
  logic             popped;
  logic             full;
  logic             empty;
  logic             busy;
  logic [LVL_W-1:0] level;
  logic [LVL_W-1:0] eops;
  logic [WORD_W-1:0] wr_word;
  logic [WORD_W-1:0] rd_word;

  assign in_ready = !full;
  assign pushed   = in_valid && in_ready;
  assign popped   = out_valid && out_ready;
  assign wr_word  = {in_sop, in_eop, in_data};

  pff_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pushed),
    .wr_word (wr_word),
    .rd_en   (popped),
    .rd_word (rd_word)
  );

  pff_level #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_level (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (pushed),
    .push_eop (in_eop),
    .pop      (popped),
    .pop_eop  (out_eop),
    .level    (level),
    .eops     (eops),
    .full     (full),
    .empty    (empty)
  );

  pff_gate #(.FILL(FILL), .LVL_W(LVL_W)) u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .level      (level),
    .eops       (eops),
    .empty      (empty),
    .pop        (popped),
    .pop_eop    (out_eop),
    .busy       (busy),
    .release_ok (out_valid)
  );

  assign out_sop  = rd_word[WORD_W-1];
  assign out_eop  = rd_word[WORD_W-2];
  assign out_data = rd_word[DATA_W-1:0];

endmodule

// File: rtl/pff_checker.sv
module pff_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 5,
  parameter int unsigned FILL   = 8,
  parameter int unsigned DEPTH  = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              out_sop,
  input logic              out_eop,
  input logic [LVL_W-1:0]  level,
  input logic [LVL_W-1:0]  eops
);

  // R3: an offered word is refused while full and the count does not move
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !(out_valid && out_ready)) |=> $stable(level));

  // R9: the count never exceeds capacity
  p_level_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LVL_W'(DEPTH));

  // R4: the output only opens on a met release condition
  p_release_cond_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> ((level >= LVL_W'(FILL)) || (eops != '0)));

  // R5: no bubble inside a packet
  p_no_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && out_eop)) |=> out_valid);

  // R6: a stalled word is held
  p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));

  // R7: the gate closes after the end word
  p_regate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> !out_valid);

endmodule

bind pkt_fill_fifo pff_checker #(
  .DATA_W (DATA_W),
  .LVL_W  (LVL_W),
  .FILL   (FILL),
  .DEPTH  (DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_sop   (out_sop),
  .out_eop   (out_eop),
  .level     (level),
  .eops      (eops)
);

// File: tb/sim_pkt_fill_fifo.sv
module sim_pkt_fill_fifo;
  localparam int FILL  = 4 * 2;
  localparam int DEPTH = FILL + 2 + 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        in_sop = 1'b0;
  logic        in_eop = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        out_sop;
  logic        out_eop;

  int  nchk = 0;
  int  nerr = 0;
  bit  done = 0;
  bit  rand_rdy = 0;
  logic [17:0] sb [$];

  always #10 clk = ~clk;

  pkt_fill_fifo u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sop(in_sop), .in_eop(in_eop),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sop(out_sop), .out_eop(out_eop)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  // Monitor / scoreboard, sampled mid-cycle
  bit          mid_pkt = 0;
  bit          eop_taken = 0;
  bit          hold_pend = 0;
  logic [17:0] held;
  always @(negedge clk) begin
    if (!rst_n) begin
      mid_pkt = 0; eop_taken = 0; hold_pend = 0;
    end else begin
      if (eop_taken)
        chk(!out_valid, "R7", "valid after end word", int'(out_valid), 0);
      else if (mid_pkt)
        chk(out_valid, "R5", "gap inside packet", int'(out_valid), 1);
      if (hold_pend)
        chk(out_valid && ({out_sop, out_eop, out_data} == held), "R6",
            "stalled word changed", int'({out_sop, out_eop, out_data}), int'(held));
      if (out_valid && out_ready) begin
        if (sb.size() == 0) begin
          chk(0, "R1", "unexpected word", int'(out_data), 0);
        end else begin
          logic [17:0] exp_w;
          exp_w = sb.pop_front();
          chk(out_data == exp_w[15:0], "R1", "data", int'(out_data), int'(exp_w[15:0]));
          chk({out_sop, out_eop} == exp_w[17:16], "R2", "sop/eop flags",
              int'({out_sop, out_eop}), int'(exp_w[17:16]));
        end
        mid_pkt = !out_eop;
        eop_taken = out_eop;
        hold_pend = 0;
      end else begin
        eop_taken = 0;
        hold_pend = out_valid;
        held = {out_sop, out_eop, out_data};
      end
    end
  end

  // Random backpressure
  always @(posedge clk) begin
    if (rand_rdy) begin
      #1 out_ready = ($urandom_range(0, 3) != 0);
    end
  end

  // Drivers: called at posedge + 1
  task automatic push_word(input logic [15:0] d, input bit s, input bit e);
    in_valid = 1; in_data = d; in_sop = s; in_eop = e;
    forever begin
      @(negedge clk);
      if (in_ready) begin
        sb.push_back({s, e, d});
        @(posedge clk); #1;
        break;
      end
      @(posedge clk); #1;
    end
    in_valid = 0; in_sop = 0; in_eop = 0;
  endtask

  task automatic send_pkt(input int len, input logic [15:0] base, input int gap);
    for (int i = 0; i < len; i++) begin
      push_word(base + 16'(i), i == 0, i == len - 1);
      if (gap > 0) repeat (gap) begin @(posedge clk); #1; end
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic drain();
    while (sb.size() != 0) cycles(1);
    cycles(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    // R8: reset state
    cycles(3);
    @(negedge clk);
    chk(!out_valid, "R8", "out_valid in reset", int'(out_valid), 0);
    chk(in_ready, "R8", "in_ready in reset", int'(in_ready), 1);
    @(posedge clk); #1 rst_n = 1;
    cycles(2);

    // R4: short packet waits for its end word
    out_ready = 0;
    push_word(16'h0100, 1, 0);
    push_word(16'h0101, 0, 0);
    repeat (4) @(negedge clk);
    chk(!out_valid, "R4", "open before end word", int'(out_valid), 0);
    @(posedge clk); #1;
    push_word(16'h0102, 0, 1);
    repeat (2) @(negedge clk);
    chk(out_valid, "R4", "not open after end word", int'(out_valid), 1);
    chk(out_sop, "R2", "first word start flag", int'(out_sop), 1);
    @(posedge clk); #1 out_ready = 1;
    drain();

    // R4: release by count with no end word stored
    out_ready = 0;
    for (int i = 0; i < 7; i++) push_word(16'h0200 + 16'(i), i == 0, 0);
    repeat (3) @(negedge clk);
    chk(!out_valid, "R4", "open below threshold", int'(out_valid), 0);
    @(posedge clk); #1;
    push_word(16'h0207, 0, 0);
    repeat (3) @(negedge clk);
    chk(out_valid, "R4", "not open at threshold", int'(out_valid), 1);
    @(posedge clk); #1;
    for (int i = 8; i < 12; i++) push_word(16'h0200 + 16'(i), 0, i == 11);
    out_ready = 1;
    drain();

    // R3 / R9: fill to capacity with the sink stalled
    out_ready = 0;
    for (int i = 0; i < DEPTH; i++) begin
      if (i == DEPTH - 1) begin
        @(negedge clk);
        chk(in_ready, "R9", "full too early", int'(in_ready), 1);
        @(posedge clk); #1;
      end
      push_word(16'h0300 + 16'(i), (i % 4) == 0, (i % 4) == 3);
    end
    @(negedge clk);
    chk(!in_ready, "R9", "not full at capacity", int'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1; in_data = 16'hDEAD; in_sop = 1; in_eop = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(!in_ready, "R3", "ready while full", int'(in_ready), 0);
    end
    @(posedge clk); #1 in_valid = 0; in_sop = 0; in_eop = 0;
    out_ready = 1;
    drain();
    @(negedge clk);
    chk(!out_valid, "R3", "extra word after drain", int'(out_valid), 0);
    chk(in_ready, "R3", "ready after drain", int'(in_ready), 1);
    @(posedge clk); #1;

    // R1 / R2 / R5 / R6: random lengths, gaps and backpressure
    rand_rdy = 1;
    for (int p = 0; p < 30; p++)
      send_pkt($urandom_range(1, FILL), 16'h1000 + 16'(p * 16), $urandom_range(0, 2));
    drain();
    rand_rdy = 0;
    @(posedge clk); #1 out_ready = 0;

    // R8: reset while a release is in progress
    for (int i = 0; i < 9; i++) push_word(16'h0400 + 16'(i), i == 0, 0);
    cycles(2);
    rst_n = 0;
    sb.delete();
    cycles(2);
    @(negedge clk);
    chk(!out_valid, "R8", "valid held through reset", int'(out_valid), 0);
    chk(in_ready, "R8", "not ready in reset", int'(in_ready), 1);
    @(posedge clk); #1 rst_n = 1;
    out_ready = 1;
    repeat (4) @(negedge clk);
    chk(!out_valid, "R8", "stale word after reset", int'(out_valid), 0);
    @(posedge clk); #1;
    send_pkt(3, 16'h0500, 0);
    drain();
    chk(sb.size() == 0, "R1", "words left undelivered", sb.size(), 0);

    report();
  end

endmodule